// File: doc/BRIEF.md
# DDR I/Q Transmit Interleaver

This block feeds a 6-lane double-data-rate transmit bus from a stream of 12-bit I/Q samples. It runs on one core clock, and that clock is also forwarded with the data as the feedback clock. In each core cycle it presents two 6-bit beats: `tx_rise` goes out on the rising edge and `tx_fall` on the falling edge. A DDR output cell outside the block serializes them. Every sample is cut into upper halves (bits [11:6]) and lower halves (bits [5:0]). The beats leave as I upper, Q upper, I lower, Q lower, so one sample slot lasts two core cycles.

A frame strobe marks the frame period. In single-channel mode the frame is one slot long. In dual-channel mode the frame is two slots: a whole channel-0 sample followed by a whole channel-1 sample. The strobe is high for the first half of the frame, so a receiver can align on its rising edge.

Samples come in over a valid/ready handshake. Ready is raised for one cycle ahead of each slot. If no usable sample is offered in that cycle, the slot carries zeros and a sticky underflow flag is raised. The channel mode is captured once, just after reset, and holds until the next reset.

Top module: `ddr_iq_tx`

## Requirements
- R1: While `rst_n` is low, and after reset until the first sample is accepted, `tx_rise`, `tx_fall`, `tx_frame` and `underflow` are 0. Handshake cycles without an accepted sample in this idle state raise no underflow.
- R2: Take an accepted sample with `s_i`=I and `s_q`=Q. In the next cycle `tx_rise`=I[11:6] and `tx_fall`=Q[11:6]. In the cycle after that, `tx_rise`=I[5:0] and `tx_fall`=Q[5:0].
- R3: `s_ready` is never high in two consecutive cycles. Once transmission has started it is high exactly every second cycle, one cycle per slot. A transfer happens only when `s_valid` and `s_ready` are both high.
- R4: In single-channel mode (`dual_mode`=0) each frame is one two-cycle slot, and `tx_frame` is 1 in the first cycle and 0 in the second. `s_chan` is ignored.
- R5: In dual-channel mode (`dual_mode`=1) slots alternate channel 0 then channel 1, starting with channel 0 at a frame boundary. `tx_frame` is 1 for both cycles of the channel-0 slot and 0 for both cycles of the channel-1 slot.
- R6: In dual mode, a sample whose `s_chan` differs from the channel of the coming slot is dropped. Before transmission starts, such a sample does not start it. While running, it is handled as a missing sample (R7).
- R7: While running, a slot with no accepted sample carries zeros on both lanes and the frame cadence continues. `underflow` goes to 1 in the cycle after that handshake cycle and stays 1 until reset.
- R8: `dual_mode` is taken at the first clock edge after the internal reset releases. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also forwarded as the feedback clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 selects two channels, 0 selects one; captured after reset |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block takes a sample this cycle |
| s_chan | input | 1 | Channel of the offered sample (0 or 1) |
| s_i | input | SAMPLE_W | In-phase sample |
| s_q | input | SAMPLE_W | Quadrature sample |
| tx_rise | output | SAMPLE_W/2 | Beat for the rising clock edge |
| tx_fall | output | SAMPLE_W/2 | Beat for the falling clock edge |
| tx_frame | output | 1 | Frame strobe, high for the first half of each frame |
| underflow | output | 1 | Sticky flag: a running slot lacked a sample |

## Verification
All results follow a single handshake cycle. The upper halves and the strobe are due one cycle after a ready cycle, and the lower halves two cycles after it. The underflow flag is due one cycle after the ready cycle in which no sample was taken. The bench drives inputs and samples outputs at the falling edge. At each falling edge it compares the outputs with an expectation computed one cycle earlier from the handshake it has just driven, so every check lands exactly on the cycle its result is due. The ready cadence is checked against the previous cycle's ready, which also covers the first handshake after the start.

// File: rtl/ddr_iq_pkg.sv
package ddr_iq_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } chan_mode_e;

  localparam int unsigned PHASE_W = 2;

endpackage

// File: rtl/ddr_iq_seq.sv
module ddr_iq_seq
  import ddr_iq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  chan_mode_e         mode,
  input  logic               running,
  output logic               take,
  output logic               exp_chan,
  output logic               head_nxt
);

  logic [PHASE_W-1:0] ph_q, ph_d;
  logic               last;

  always_comb begin
    last     = (mode == MODE_DUAL) ? (ph_q == 2'd3) : (ph_q == 2'd1);
    ph_d     = last ? '0 : ph_q + 2'd1;
    take     = running ? ph_q[0] : last;
    exp_chan = (mode == MODE_DUAL) & ~ph_q[1];
    head_nxt = (mode == MODE_DUAL) ? ~ph_d[1] : (ph_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  // ready is only one cycle wide
  assert_ready_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // single mode frames never reach the upper phases
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SINGLE) |=> (ph_q <= 2'd1));

endmodule

// File: rtl/ddr_iq_intake.sv
module ddr_iq_intake
  import ddr_iq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_e mode,
  input  logic       take,
  input  logic       exp_chan,
  input  logic       s_valid,
  input  logic       s_chan,
  output logic       accept,
  output logic       running,
  output logic       underflow
);

  logic run_d, uf_d, run_en, uf_en;

  always_comb begin
    accept = take & s_valid & ((mode != MODE_DUAL) | (s_chan == exp_chan));
    run_en = accept & ~running;
    run_d  = 1'b1;
    uf_en  = take & running & ~accept;
    uf_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (run_en) running   <= run_d;
      if (uf_en)  underflow <= uf_d;
    end
  end

  assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_uf_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !underflow);

endmodule

// File: rtl/ddr_iq_beatmux.sv
module ddr_iq_beatmux #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  accept,
  input  logic                  running,
  input  logic                  head_nxt,
  input  logic [SAMPLE_W-1:0]   s_i,
  input  logic [SAMPLE_W-1:0]   s_q,
  output logic [SAMPLE_W/2-1:0] tx_rise,
  output logic [SAMPLE_W/2-1:0] tx_fall,
  output logic                  tx_frame
);

  localparam int unsigned LANE_W = SAMPLE_W / 2;

  logic [LANE_W-1:0] hold_i_q, hold_q_q, hold_i_d, hold_q_d;
  logic [LANE_W-1:0] rise_d, fall_d;
  logic              frame_d;

  always_comb begin
    rise_d   = tx_rise;
    fall_d   = tx_fall;
    hold_i_d = hold_i_q;
    hold_q_d = hold_q_q;
    if (take) begin
      if (accept) begin
        rise_d   = s_i[SAMPLE_W-1:LANE_W];
        fall_d   = s_q[SAMPLE_W-1:LANE_W];
        hold_i_d = s_i[LANE_W-1:0];
        hold_q_d = s_q[LANE_W-1:0];
      end else begin
        rise_d   = '0;
        fall_d   = '0;
        hold_i_d = '0;
        hold_q_d = '0;
      end
    end else if (running) begin
      rise_d = hold_i_q;
      fall_d = hold_q_q;
    end
    frame_d = (running | accept) & head_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rise  <= '0;
      tx_fall  <= '0;
      tx_frame <= 1'b0;
      hold_i_q <= '0;
      hold_q_q <= '0;
    end else begin
      tx_rise  <= rise_d;
      tx_fall  <= fall_d;
      tx_frame <= frame_d;
      hold_i_q <= hold_i_d;
      hold_q_q <= hold_q_d;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (tx_rise == '0 && tx_fall == '0 && !tx_frame));

  // lower halves follow the upper halves of the same sample
  assert_lower_from_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !take) |=> (tx_rise == $past(hold_i_q) && tx_fall == $past(hold_q_q)));

endmodule

// File: rtl/ddr_iq_tx.sv
module ddr_iq_tx
  import ddr_iq_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dual_mode,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic                  s_chan,
  input  logic [SAMPLE_W-1:0]   s_i,
  input  logic [SAMPLE_W-1:0]   s_q,
  output logic [SAMPLE_W/2-1:0] tx_rise,
  output logic [SAMPLE_W/2-1:0] tx_fall,
  output logic                  tx_frame,
  output logic                  underflow
);

  logic [1:0] rsync_q;
  logic       core_rst_n;
  logic       cfg_done_q;
  chan_mode_e mode_q;
  logic       take, exp_chan, head_nxt, accept, running;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cfg_done_q <= 1'b0;
      mode_q     <= MODE_SINGLE;
    end else begin
      cfg_done_q <= 1'b1;
      if (!cfg_done_q) mode_q <= chan_mode_e'(dual_mode);
    end
  end

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    cfg_done_q |=> $stable(mode_q));

  ddr_iq_seq u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .mode     (mode_q),
    .running  (running),
    .take     (take),
    .exp_chan (exp_chan),
    .head_nxt (head_nxt)
  );

  ddr_iq_intake u_intake (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .mode      (mode_q),
    .take      (take),
    .exp_chan  (exp_chan),
    .s_valid   (s_valid),
    .s_chan    (s_chan),
    .accept    (accept),
    .running   (running),
    .underflow (underflow)
  );

  ddr_iq_beatmux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .take     (take),
    .accept   (accept),
    .running  (running),
    .head_nxt (head_nxt),
    .s_i      (s_i),
    .s_q      (s_q),
    .tx_rise  (tx_rise),
    .tx_fall  (tx_fall),
    .tx_frame (tx_frame)
  );

  assign s_ready = take;

endmodule

// File: tb/sim_ddr_iq_tx.sv
module sim_ddr_iq_tx;

  localparam int W = 12;
  localparam int L = W / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dual_mode;
  logic         s_valid;
  logic         s_ready;
  logic         s_chan;
  logic [W-1:0] s_i, s_q;
  logic [L-1:0] tx_rise, tx_fall;
  logic         tx_frame, underflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [L-1:0] e_rise, e_fall, p_i, p_q;
  logic         e_frame, e_uf, e_run, prev_ready, nxt, mode;

  ddr_iq_tx #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_chan(s_chan),
    .s_i(s_i), .s_q(s_q),
    .tx_rise(tx_rise), .tx_fall(tx_fall), .tx_frame(tx_frame),
    .underflow(underflow)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    e_rise = '0; e_fall = '0; p_i = '0; p_q = '0;
    e_frame = 0; e_uf = 0; e_run = 0; prev_ready = 0; nxt = 0;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 0; s_valid = 0; s_chan = 0; s_i = '0; s_q = '0;
    dual_mode = m; mode = m;
    repeat (3) @(negedge clk);
    chk(tx_rise == 0 && tx_fall == 0 && !tx_frame, "R1 reset lanes",
        {tx_rise, tx_fall, tx_frame}, 0);
    chk(!s_ready && !underflow, "R1 reset ready/underflow", {s_ready, underflow}, 0);
    rst_n = 1;
    model_clear();
  endtask

  // one cycle: check what is due now, then drive this cycle's inputs
  task automatic step(input int pv, input int pw, input string tag);
    bit           v, ch, acc;
    logic [W-1:0] vi, vq;
    @(negedge clk);
    if (e_run) chk(s_ready == !prev_ready, "R3 ready cadence", s_ready, !prev_ready);
    else       chk(!(s_ready && prev_ready), "R3 ready doubled", s_ready, 0);
    chk(tx_rise == e_rise && tx_fall == e_fall,
        e_run ? {"R2 lanes", tag} : {"R1 idle lanes", tag},
        {tx_rise, tx_fall}, {e_rise, e_fall});
    chk(tx_frame == e_frame, mode ? {"R5 frame", tag} : {"R4 frame", tag},
        tx_frame, e_frame);
    chk(underflow == e_uf, {"R7 underflow", tag}, underflow, e_uf);

    v  = ($urandom_range(99) < pv);
    vi = W'($urandom); vq = W'($urandom);
    if (s_ready) begin
      ch  = mode ? (($urandom_range(99) < pw) ? ~nxt : nxt) : 1'($urandom);
      acc = v && (!mode || ch == nxt);
      if (acc) begin
        e_rise = vi[W-1:L]; e_fall = vq[W-1:L];
        p_i = vi[L-1:0]; p_q = vq[L-1:0];
      end else if (e_run) begin
        e_rise = '0; e_fall = '0; p_i = '0; p_q = '0; e_uf = 1;
      end
      if (e_run || acc) begin
        e_run   = 1;
        e_frame = mode ? (nxt == 0) : 1'b1;
        nxt     = mode ? ~nxt : 1'b0;
      end
    end else begin
      ch = 1'($urandom);
      if (e_run) begin
        e_rise = p_i; e_fall = p_q;
        if (!mode) e_frame = 0;
      end
    end
    prev_ready = s_ready;
    s_valid = v; s_chan = ch; s_i = vi; s_q = vq;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; dual_mode = 0; mode = 0;
    s_valid = 0; s_chan = 0; s_i = '0; s_q = '0;
    model_clear();

    // single channel: idle, then full stream, then gaps
    do_reset(1'b0);
    repeat (12)  step(0, 0, " idle R1");
    repeat (200) step(100, 0, " R4 stream");
    repeat (200) step(70, 0, " R4 R7 gaps");
    // mode pin toggles while running: must not matter
    dual_mode = 1;
    repeat (60) step(90, 0, " R8 single held");

    // dual channel: wrong channel before start must not start it
    do_reset(1'b1);
    repeat (10) step(0, 0, " idle R1");
    repeat (8)  step(100, 100, " R6 prestart");
    repeat (200) step(100, 0, " R5 stream");
    repeat (200) step(85, 20, " R6 R7 mixed");
    dual_mode = 0;
    repeat (60) step(100, 0, " R8 dual held");

    // reset clears the sticky flag
    do_reset(1'b0);
    repeat (4) step(0, 0, " R7 cleared");
    repeat (40) step(100, 0, " R2 restart");
    finish_run();
  end

endmodule